// File: doc/BRIEF.md
# Minutes and Seconds Stopwatch

This block is a synchronous stopwatch core that counts elapsed time from 00:00 up to 59:59 and shows it as four decimal digits. Three control inputs drive it. One starts or resumes counting. One pauses it. One clears the count back to zero. Time moves forward only on a one-cycle tick enable. That tick comes from a prescaler outside this block, normally one pulse per second.

The count is a chain of two base-sixty fields, seconds first and then minutes. Each field is a units digit that counts 0 to 9, followed by a tens digit that counts 0 to 5. When the minutes field wraps, the block raises a single-cycle carry that an hours stage can count. Display decoding, button debouncing and the hours stage itself live elsewhere.

Top module: `stopwatch_mmss`

## Requirements
- R1: While `clear` is high at a clock edge, all four digits become 0, `running` becomes 0 and `hour_carry` becomes 0 after that edge, whatever `start_btn`, `stop_btn` and `tick_en` hold.
- R2: With `clear` low, `start_btn` high and `stop_btn` low at an edge, `running` is 1 after that edge. `running` is 1 exactly while the watch is in the running state.
- R3: The count advances by one second at an edge only when `tick_en` is high and `running` was already 1 before that edge. A tick sampled at the same edge as a start request is not counted.
- R4: With `clear` low and `stop_btn` high at an edge, `running` is 0 after that edge, even when `start_btn` is also high. A tick sampled at that same edge is still counted, because the watch was running before the edge.
- R5: A start request after a pause resumes counting from the held digits, not from zero.
- R6: `sec_units` is a 4-bit BCD digit from 0 to 9. When it wraps from 9 to 0, `sec_tens` increments.
- R7: `sec_tens` is a 3-bit digit from 0 to 5. On the tick after 59 seconds, the seconds read 00 and `min_units` increments.
- R8: `min_units` (BCD, 0 to 9) and `min_tens` (3-bit, 0 to 5) follow the same rules as the seconds digits, so the minutes field runs from 00 to 59.
- R9: On the tick that turns 59:59 into 00:00, `hour_carry` is 1 for exactly the one cycle in which 00:00 first shows. It is 0 at all other times.
- R10: While the watch is paused, `tick_en` pulses leave all digits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; every state change happens on its rising edge |
| clear | input | 1 | Synchronous clear of the count and run state; highest priority |
| start_btn | input | 1 | Request to enter or resume the running state |
| stop_btn | input | 1 | Request to pause; wins over `start_btn` |
| tick_en | input | 1 | One-cycle enable, once per counted second |
| min_tens | output | 3 | Minutes tens digit, 0 to 5 |
| min_units | output | 4 | Minutes units digit, BCD 0 to 9 |
| sec_tens | output | 3 | Seconds tens digit, 0 to 5 |
| sec_units | output | 4 | Seconds units digit, BCD 0 to 9 |
| running | output | 1 | High while the watch is counting |
| hour_carry | output | 1 | One-cycle pulse when minutes wrap from 59 to 00 |

## Verification
The bench builds the block with its default digit moduli: ten for units and six for tens. With a tick on every cycle, a full hour is 3600 cycles, so the bench can step through every digit rollover, including the full 59:59 to 00:00 wrap and its carry pulse. A table of control vectors covers these cases:
- ticks while paused,
- a tick in the same cycle as start,
- a tick in the same cycle as stop,
- start and stop together,
- clear together with start.

Directed sequences then cover the rollovers and a pause in the middle of a count.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic {
    SW_PAUSED  = 1'b0,
    SW_RUNNING = 1'b1
  } run_state_e;

  function automatic int digit_bits(input int modulus);
    return (modulus <= 2) ? 1 : $clog2(modulus);
  endfunction
endpackage

// File: rtl/sw_digit.sv
module sw_digit #(
  parameter int MOD = 10,
  parameter int W   = sw_pkg::digit_bits(MOD)
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  assign wrap = step && (value == LAST);

  always_ff @(posedge clk) begin
    if (clear)     value <= '0;
    else if (step) value <= wrap ? '0 : value + 1'b1;
  end

  // Digit never leaves its range (R6 units, R7/R8 tens)
  assert_digit_bound_R6: assert property (@(posedge clk) disable iff (clear)
    value <= LAST);

  // Without a step the digit holds
  assert_hold_without_step_R10: assert property (@(posedge clk) disable iff (clear)
    !step |=> $stable(value));
endmodule

// File: rtl/sw_field.sv
module sw_field #(
  parameter int UNITS_MOD = 10,
  parameter int TENS_MOD  = 6,
  localparam int UW = sw_pkg::digit_bits(UNITS_MOD),
  localparam int TW = sw_pkg::digit_bits(TENS_MOD)
) (
  input  logic          clk,
  input  logic          clear,
  input  logic          step,
  output logic [UW-1:0] units,
  output logic [TW-1:0] tens,
  output logic          wrap
);
  logic units_wrap;

  sw_digit #(.MOD(UNITS_MOD), .W(UW)) u_units (
    .clk   (clk),
    .clear (clear),
    .step  (step),
    .value (units),
    .wrap  (units_wrap)
  );

  sw_digit #(.MOD(TENS_MOD), .W(TW)) u_tens (
    .clk   (clk),
    .clear (clear),
    .step  (units_wrap),
    .value (tens),
    .wrap  (wrap)
  );

  // Units wrapping to zero moves the tens digit (R6)
  assert_tens_follow_R6: assert property (@(posedge clk) disable iff (clear)
    units_wrap |=> (units == '0) && !$stable(tens));
endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl (
  input  logic clk,
  input  logic clear,
  input  logic start_btn,
  input  logic stop_btn,
  output logic running
);
  import sw_pkg::*;

  run_state_e state_q;

  always_ff @(posedge clk) begin
    if (clear)          state_q <= SW_PAUSED;
    else if (stop_btn)  state_q <= SW_PAUSED;
    else if (start_btn) state_q <= SW_RUNNING;
  end

  assign running = (state_q == SW_RUNNING);

  assert_clear_pauses_R1: assert property (@(posedge clk)
    clear |=> !running);

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (clear)
    (start_btn && !stop_btn) |=> running);

  assert_stop_wins_R4: assert property (@(posedge clk) disable iff (clear)
    stop_btn |=> !running);
endmodule

// File: rtl/stopwatch_mmss.sv
module stopwatch_mmss #(
  parameter int UNITS_MOD = 10,
  parameter int TENS_MOD  = 6,
  localparam int UW = sw_pkg::digit_bits(UNITS_MOD),
  localparam int TW = sw_pkg::digit_bits(TENS_MOD),
  localparam int FIELDS = 2
) (
  input  logic          clk,
  input  logic          clear,
  input  logic          start_btn,
  input  logic          stop_btn,
  input  logic          tick_en,
  output logic [TW-1:0] min_tens,
  output logic [UW-1:0] min_units,
  output logic [TW-1:0] sec_tens,
  output logic [UW-1:0] sec_units,
  output logic          running,
  output logic          hour_carry
);
  logic [UW-1:0] units_d [FIELDS];
  logic [TW-1:0] tens_d  [FIELDS];
  logic [FIELDS:0] chain;

  sw_ctrl u_ctrl (
    .clk       (clk),
    .clear     (clear),
    .start_btn (start_btn),
    .stop_btn  (stop_btn),
    .running   (running)
  );

  assign chain[0] = running && tick_en;

  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    sw_field #(.UNITS_MOD(UNITS_MOD), .TENS_MOD(TENS_MOD)) u_field (
      .clk   (clk),
      .clear (clear),
      .step  (chain[g]),
      .units (units_d[g]),
      .tens  (tens_d[g]),
      .wrap  (chain[g+1])
    );
  end

  assign sec_units = units_d[0];
  assign sec_tens  = tens_d[0];
  assign min_units = units_d[1];
  assign min_tens  = tens_d[1];

  always_ff @(posedge clk) begin
    if (clear) hour_carry <= 1'b0;
    else       hour_carry <= chain[FIELDS];
  end

  // Count frozen without a counted tick (R3, R10)
  assert_freeze_R10: assert property (@(posedge clk) disable iff (clear)
    !(running && tick_en) |=> $stable({min_tens, min_units, sec_tens, sec_units}));

  // Carry only while 00:00 shows, and never two cycles long (R9)
  assert_carry_at_zero_R9: assert property (@(posedge clk) disable iff (clear)
    hour_carry |-> ({min_tens, min_units, sec_tens, sec_units} == '0));

  assert_carry_single_R9: assert property (@(posedge clk) disable iff (clear)
    hour_carry |=> !hour_carry);

  // Seconds wrap feeds minutes (R7)
  assert_sec_to_min_R7: assert property (@(posedge clk) disable iff (clear)
    chain[1] |=> (sec_units == '0) && (sec_tens == '0) && !$stable(min_units));
endmodule

// File: tb/tb_stopwatch_mmss.sv
module tb_stopwatch_mmss;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic clk = 1'b0;
  logic clear = 1'b1;
  logic start_btn = 1'b0;
  logic stop_btn = 1'b0;
  logic tick_en = 1'b0;
  logic [2:0] min_tens, sec_tens;
  logic [3:0] min_units, sec_units;
  logic running, hour_carry;

  int checks = 0;
  int errors = 0;
  int m_ts = 0;
  logic m_run = 1'b0;
  logic m_carry = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stopwatch_mmss dut (
    .clk(clk), .clear(clear), .start_btn(start_btn), .stop_btn(stop_btn),
    .tick_en(tick_en), .min_tens(min_tens), .min_units(min_units),
    .sec_tens(sec_tens), .sec_units(sec_units), .running(running),
    .hour_carry(hour_carry)
  );

  // vector: {clear, start, stop, tick, exp_running, exp_seconds[11:0]}
  localparam logic [16:0] VECS [NVEC] = '{
    {4'b0001, 1'b0, 12'd0},  // R10 tick while paused ignored
    {4'b0101, 1'b1, 12'd0},  // R3 tick in start cycle not counted
    {4'b0001, 1'b1, 12'd1},  // R3 counted tick
    {4'b0000, 1'b1, 12'd1},  // R3 no tick, no change
    {4'b0001, 1'b1, 12'd2},
    {4'b0011, 1'b0, 12'd3},  // R4 tick in stop cycle counted
    {4'b0001, 1'b0, 12'd3},  // R10
    {4'b0001, 1'b0, 12'd3},  // R10
    {4'b0110, 1'b0, 12'd3},  // R4 stop wins over start
    {4'b0100, 1'b1, 12'd3},  // R5 resume from held value
    {4'b0001, 1'b1, 12'd4},  // R5
    {4'b1101, 1'b0, 12'd0},  // R1 clear beats start
    {4'b0100, 1'b1, 12'd0}   // R2
  };

  function automatic int shown_seconds();
    return (int'(min_tens) * 10 + int'(min_units)) * 60 + int'(sec_tens) * 10 + int'(sec_units);
  endfunction

  task automatic cyc(input logic c, input logic s, input logic p, input logic t);
    clear = c; start_btn = s; stop_btn = p; tick_en = t;
    if (c) begin
      m_ts = 0; m_run = 1'b0; m_carry = 1'b0;
    end else begin
      m_carry = m_run && t && (m_ts == 3599);
      if (m_run && t) m_ts = (m_ts + 1) % 3600;
      if (p) m_run = 1'b0;
      else if (s) m_run = 1'b1;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag);
    checks++;
    if (shown_seconds() != m_ts || running !== m_run || hour_carry !== m_carry ||
        sec_units > 9 || min_units > 9 || sec_tens > 5 || min_tens > 5) begin
      errors++;
      $display("FAIL %s: got %0d%0d:%0d%0d run=%0b carry=%0b, expected %0d:%0d run=%0b carry=%0b",
               tag, min_tens, min_units, sec_tens, sec_units, running, hour_carry,
               m_ts / 60, m_ts % 60, m_run, m_carry);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 1);
    chk("R1 reset state");

    for (int i = 0; i < NVEC; i++) begin
      cyc(VECS[i][16], VECS[i][15], VECS[i][14], VECS[i][13]);
      checks++;
      if (running !== VECS[i][12] || shown_seconds() != int'(VECS[i][11:0]) || hour_carry !== 1'b0) begin
        errors++;
        $display("FAIL vector %0d (R1..R5,R10): got run=%0b secs=%0d carry=%0b, expected run=%0b secs=%0d carry=0",
                 i, running, shown_seconds(), hour_carry, VECS[i][12], VECS[i][11:0]);
      end
    end

    // R6 R7 R8: walk every second of the hour
    for (int n = 1; n < 3600; n++) begin
      cyc(0, 0, 0, 1);
      if (n == 10) chk("R6 units wrap");
      else if (n == 60) chk("R7 seconds wrap");
      else if (n == 600) chk("R8 minute units wrap");
      else chk("R8 count");
    end
    cyc(0, 0, 0, 1);
    chk("R9 carry with 00:00");
    cyc(0, 0, 0, 0);
    chk("R9 carry one cycle");

    // R10 pause mid-count, R5 resume
    repeat (37) cyc(0, 0, 0, 1);
    cyc(0, 0, 1, 0);
    for (int k = 0; k < 4; k++) begin
      cyc(0, 0, 0, 1);
      chk("R10 paused ticks");
    end
    cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R5 resume after pause");

    // R1 clear while running and ticking
    cyc(1, 0, 0, 1);
    chk("R1 clear while running");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule